// File: doc/BRIEF.md
# Destructive-Read Memory Access Sequencer

This block sits between a simple request/ready bus master and a memory array whose reads wipe the stored word. A requester holds `req_valid` with the operation fields until `req_ready` pulses for one cycle. For a read, `rsp_rdata` carries the word in that same cycle. The sequencer drives one array command for the operation. Reads then receive an automatic restoring write of the captured word to the same address. This write is flagged on `mem_wb` so the array side can tell it apart from writes the requester asked for. Writes carry per-byte enables, so a byte write leaves the other byte of the word untouched.

Two separately programmed wait counts shape the timing. `cfg_access_wait` stretches the time before `req_ready`. `cfg_cycle_wait` adds recovery cycles after the operation, and the restoring write comes before that recovery. A power-enable input keeps the array supplied while set. When it is clear, the array is only powered while an operation is in service. Any operation that finds the supply fresh waits until it has been up for four cycles.

The controller is a single state machine. IDLE accepts a request. It goes to ISSUE if the array is already awake, and to WAKE otherwise. WAKE goes to ISSUE once the supply has been up long enough. ISSUE drives the array command, and SAMPLE captures the read word in the following cycle. SAMPLE goes to ACCESS when the access wait is non-zero, and to RESPOND when it is zero. ACCESS counts the access wait and then goes to RESPOND. RESPOND pulses ready. After a read it goes to WBACK, which drives the restoring write. After a write, and after WBACK, the machine goes to RECOVER when the cycle wait is non-zero and back to IDLE when it is zero. RECOVER counts the cycle wait and then returns to IDLE.

Top module: `drmem_seq`

## Requirements
- R1: After reset the sequencer is idle: `req_ready` is 0, `mem_cs` is 0, and `mem_pwr` equals `cfg_array_en`.
- R2: With the array awake, `req_ready` pulses for exactly one cycle, 3 + `cfg_access_wait` cycles after the clock edge that accepts the request.
- R3: A write with `req_be` = 2'b11 replaces the whole word. With a single enable set it changes only that byte (bit 0 is bits 7:0, bit 1 is bits 15:8), and the other byte keeps its value.
- R4: The array command after every read is a write to the same address, with the same data, with both byte enables set and with `mem_wb` = 1. It is issued in the cycle right after the read's `req_ready` pulse.
- R5: `mem_wb` is 0 on every array command except the restoring write, including all requester writes.
- R6: After a read's ready pulse, the next request is accepted no sooner than 2 + `cfg_cycle_wait` cycles later. After a write's ready pulse the figure is 1 + `cfg_cycle_wait` cycles.
- R7: For a read, `rsp_rdata` during the ready pulse equals the word stored before the read, even though the array destroyed it. A second read of the same address returns the same word.
- R8: `mem_pwr` is 0 while idle with `cfg_array_en` = 0. It is 1 in every cycle in which an array command is driven.
- R9: A request accepted while the array has been powered for fewer than 4 cycles is delayed until that count reaches 4. From fully unpowered this adds 4 cycles; if power was raised in the acceptance cycle itself, it adds 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_array_en | input | 1 | Keep array powered when 1 |
| cfg_access_wait | input | 4 | Extra cycles before ready |
| cfg_cycle_wait | input | 4 | Recovery cycles before the next acceptance |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for writes |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with ready |
| mem_pwr | output | 1 | Array supply enable |
| mem_cs | output | 1 | Array command strobe |
| mem_we | output | 1 | Array command is a write |
| mem_wb | output | 1 | Array write is the restoring write |
| mem_addr | output | 10 | Array word address |
| mem_wdata | output | 16 | Array write data |
| mem_be | output | 2 | Array byte enables |
| mem_rdata | input | 16 | Array read data, valid the cycle after a read command |

## Verification
A wrong state or counter shows first as a shift of the `req_ready` pulse against the cycle predicted from the two wait fields and the wake rule. It is visible on the very operation where it happens. A lost or misdirected restoring write is caught at the next array command. It is also caught later at the port, because a second read of the same address returns the poisoned word instead of the original. A byte-lane error shows on the read-back that follows the byte write.

// File: rtl/drmem_pkg.sv
package drmem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_ISSUE,
        ST_SAMPLE,
        ST_ACCESS,
        ST_RESPOND,
        ST_WBACK,
        ST_RECOVER
    } seq_state_e;

endpackage

// File: rtl/drmem_power.sv
module drmem_power #(
    parameter int WAKE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_array_en,
    input  logic busy,
    output logic mem_pwr,
    output logic awake,
    output logic wake_done
);
    localparam int CW = $clog2(WAKE_CYC + 1);

    logic [CW-1:0] up_cnt;

    assign mem_pwr = cfg_array_en | busy;

    // counts cycles the supply has been up, saturating at the wake delay
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            up_cnt <= '0;
        else if (!mem_pwr)
            up_cnt <= '0;
        else if (up_cnt != CW'(WAKE_CYC))
            up_cnt <= up_cnt + 1'b1;
    end

    assign awake     = mem_pwr && (up_cnt == CW'(WAKE_CYC));
    assign wake_done = (up_cnt >= CW'(WAKE_CYC - 1));

endmodule

// File: rtl/drmem_fsm.sv
module drmem_fsm
    import drmem_pkg::*;
#(
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [WW-1:0] cfg_access_wait,
    input  logic [WW-1:0] cfg_cycle_wait,
    input  logic          op_write,
    input  logic          awake,
    input  logic          wake_done,
    output seq_state_e    state,
    output logic          busy,
    output logic          req_ready
);
    seq_state_e    state_d;
    logic [WW-1:0] cnt, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        unique case (state)
            ST_IDLE:
                if (req_valid) state_d = awake ? ST_ISSUE : ST_WAKE;
            ST_WAKE:
                if (wake_done) state_d = ST_ISSUE;
            ST_ISSUE:
                state_d = ST_SAMPLE;
            ST_SAMPLE: begin
                cnt_d   = WW'(1);
                state_d = (cfg_access_wait == '0) ? ST_RESPOND : ST_ACCESS;
            end
            ST_ACCESS:
                if (cnt >= cfg_access_wait) state_d = ST_RESPOND;
                else cnt_d = cnt + 1'b1;
            ST_RESPOND: begin
                cnt_d = WW'(1);
                if (!op_write)                 state_d = ST_WBACK;
                else if (cfg_cycle_wait == '0) state_d = ST_IDLE;
                else                           state_d = ST_RECOVER;
            end
            ST_WBACK: begin
                cnt_d   = WW'(1);
                state_d = (cfg_cycle_wait == '0) ? ST_IDLE : ST_RECOVER;
            end
            ST_RECOVER:
                if (cnt >= cfg_cycle_wait) state_d = ST_IDLE;
                else cnt_d = cnt + 1'b1;
            default:
                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        req_ready = (state == ST_RESPOND);
    end

    a_r2_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    a_r9_issue_when_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE) |-> awake);

endmodule

// File: rtl/drmem_datapath.sv
module drmem_datapath
    import drmem_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_state_e      state,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [DW/8-1:0] req_be,
    input  logic [DW-1:0]   mem_rdata,
    output logic            op_write,
    output logic [DW-1:0]   rsp_rdata,
    output logic            mem_cs,
    output logic            mem_we,
    output logic            mem_wb,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [DW/8-1:0] mem_be
);
    localparam int NB = DW / 8;

    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_wdata;
    logic [NB-1:0] op_be;
    logic [DW-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_write <= 1'b0;
            op_addr  <= '0;
            op_wdata <= '0;
            op_be    <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            op_write <= req_write;
            op_addr  <= req_addr;
            op_wdata <= req_wdata;
            op_be    <= req_be;
        end
    end

    // capture per byte lane in the cycle after the read command
    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cap_q[8*b +: 8] <= '0;
            else if (state == ST_SAMPLE && !op_write)
                cap_q[8*b +: 8] <= mem_rdata[8*b +: 8];
        end
    end

    assign rsp_rdata = cap_q;

    always_comb begin
        mem_cs    = 1'b0;
        mem_we    = 1'b0;
        mem_wb    = 1'b0;
        mem_addr  = op_addr;
        mem_wdata = op_wdata;
        mem_be    = {NB{1'b1}};
        unique case (state)
            ST_ISSUE: begin
                mem_cs = 1'b1;
                mem_we = op_write;
                if (op_write) mem_be = op_be;
            end
            ST_WBACK: begin
                mem_cs    = 1'b1;
                mem_we    = 1'b1;
                mem_wb    = 1'b1;
                mem_wdata = cap_q;
            end
            default: ;
        endcase
    end

    a_r5_wb_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wb |-> !op_write);

endmodule

// File: rtl/drmem_seq.sv
module drmem_seq
    import drmem_pkg::*;
#(
    parameter int AW       = 10,
    parameter int DW       = 16,
    parameter int WW       = 4,
    parameter int WAKE_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_array_en,
    input  logic [WW-1:0]   cfg_access_wait,
    input  logic [WW-1:0]   cfg_cycle_wait,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [DW/8-1:0] req_be,
    output logic            req_ready,
    output logic [DW-1:0]   rsp_rdata,
    output logic            mem_pwr,
    output logic            mem_cs,
    output logic            mem_we,
    output logic            mem_wb,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [DW/8-1:0] mem_be,
    input  logic [DW-1:0]   mem_rdata
);
    seq_state_e state;
    logic       busy, awake, wake_done, op_write;

    drmem_power #(.WAKE_CYC(WAKE_CYC)) u_power (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_array_en (cfg_array_en),
        .busy         (busy),
        .mem_pwr      (mem_pwr),
        .awake        (awake),
        .wake_done    (wake_done)
    );

    drmem_fsm #(.WW(WW)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .cfg_access_wait (cfg_access_wait),
        .cfg_cycle_wait  (cfg_cycle_wait),
        .op_write        (op_write),
        .awake           (awake),
        .wake_done       (wake_done),
        .state           (state),
        .busy            (busy),
        .req_ready       (req_ready)
    );

    drmem_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .mem_rdata (mem_rdata),
        .op_write  (op_write),
        .rsp_rdata (rsp_rdata),
        .mem_cs    (mem_cs),
        .mem_we    (mem_we),
        .mem_wb    (mem_wb),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be)
    );

    a_r8_cmd_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs |-> mem_pwr);

    a_r4_wb_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wb |-> $past(req_ready));

    a_r4_read_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !op_write) |=> (mem_cs && mem_we && mem_wb));

endmodule

// File: tb/drmem_seq_tb_top.sv
module drmem_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_array_en = 1'b1;
    logic [WW-1:0] cfg_access_wait = '0;
    logic [WW-1:0] cfg_cycle_wait = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    req_be = '0;
    logic          req_ready;
    logic [DW-1:0] rsp_rdata;
    logic          mem_pwr, mem_cs, mem_we, mem_wb;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [1:0]    mem_be;
    logic [DW-1:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    drmem_seq #(.AW(AW), .DW(DW), .WW(WW), .WAKE_CYC(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_array_en(cfg_array_en),
        .cfg_access_wait(cfg_access_wait), .cfg_cycle_wait(cfg_cycle_wait),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .mem_pwr(mem_pwr), .mem_cs(mem_cs),
        .mem_we(mem_we), .mem_wb(mem_wb), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // array model: destroys a word on read, checks the command stream
    logic [DW-1:0] arr    [1<<AW];
    logic [DW-1:0] shadow [1<<AW];
    bit            pend = 0;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_data;

    initial begin
        for (int i = 0; i < (1<<AW); i++) begin
            arr[i]    = DW'(i * 16'h0101) ^ 16'h5A3C;
            shadow[i] = DW'(i * 16'h0101) ^ 16'h5A3C;
        end
    end

    always @(posedge clk) begin
        if (rst_n && mem_cs) begin
            chk(mem_pwr, "R8 command while unpowered", 32'(mem_pwr), 1);
            if (pend) begin
                chk(mem_we && mem_wb && mem_addr == pend_addr && mem_wdata == pend_data && mem_be == 2'b11,
                    "R4 restoring write", {mem_we, mem_wb, mem_be, 12'(mem_addr), mem_wdata},
                    {2'b11, 2'b11, 12'(pend_addr), pend_data});
                pend = 0;
            end else begin
                chk(!mem_wb, "R5 wb flag on non-restoring command", 32'(mem_wb), 0);
            end
            if (mem_we) begin
                if (mem_be[0]) arr[mem_addr][7:0]  = mem_wdata[7:0];
                if (mem_be[1]) arr[mem_addr][15:8] = mem_wdata[15:8];
            end else begin
                mem_rdata <= arr[mem_addr];
                pend_addr = mem_addr;
                pend_data = arr[mem_addr];
                arr[mem_addr] = ~arr[mem_addr];
                pend = 1;
            end
        end
    end

    typedef struct {
        bit            is_read;
        logic [DW-1:0] data;
        int            lat;
        int            start;
        string         tag;
    } item_t;

    item_t exp_q[$];

    // monitor: compares each ready pulse against the scoreboard
    always @(negedge clk) begin
        if (rst_n && req_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected ready", 1, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(cyc - it.start == it.lat, {it.tag, " latency"}, 32'(cyc - it.start), 32'(it.lat));
                if (it.is_read)
                    chk(rsp_rdata == it.data, {it.tag, " R7 read data"}, 32'(rsp_rdata), 32'(it.data));
            end
        end
    end

    // driver: called at a falling edge, returns at the falling edge showing ready
    task automatic do_req(input bit wr, input int a, input logic [DW-1:0] d,
                          input logic [1:0] be, input int lat, input string tag);
        item_t it;
        it.is_read = !wr;
        it.lat     = lat;
        it.start   = cyc;
        it.tag     = tag;
        it.data    = shadow[a];
        if (wr) begin
            if (be[0]) shadow[a][7:0]  = d[7:0];
            if (be[1]) shadow[a][15:8] = d[15:8];
        end
        exp_q.push_back(it);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(a);
        req_wdata = d;
        req_be    = be;
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0, "R1 ready after reset", 32'(req_ready), 0);
        chk(mem_cs == 1'b0, "R1 no command after reset", 32'(mem_cs), 0);
        chk(mem_pwr == cfg_array_en, "R1 power follows enable", 32'(mem_pwr), 32'(cfg_array_en));
        idle(6);

        // aw=0 cw=0, awake
        do_req(0, 5, '0, 2'b11, 3, "R2 read");
        idle(4);
        do_req(0, 5, '0, 2'b11, 3, "R7 reread restored");
        idle(4);
        do_req(1, 9, 16'h1234, 2'b11, 3, "R3 word write");
        idle(4);
        do_req(0, 9, '0, 2'b11, 3, "R3 word readback");
        idle(4);
        do_req(1, 9, 16'hFFAB, 2'b01, 3, "R3 low byte write");
        idle(4);
        do_req(0, 9, '0, 2'b11, 3, "R3 low byte readback");
        idle(4);
        do_req(1, 9, 16'hCDEE, 2'b10, 3, "R3 high byte write");
        idle(4);
        do_req(0, 9, '0, 2'b11, 3, "R3 high byte readback");
        chk(shadow[9] == 16'hCDAB, "R3 merged expectation", 32'(shadow[9]), 32'hCDAB);
        idle(4);

        // aw=3 cw=2, back-to-back
        cfg_access_wait = 4'd3;
        cfg_cycle_wait  = 4'd2;
        idle(4);
        do_req(0, 20, '0, 2'b11, 6, "R2 read aw3");
        do_req(0, 21, '0, 2'b11, 2 + 2 + 6, "R6 read after read");
        do_req(1, 22, 16'h7E81, 2'b11, 2 + 2 + 6, "R6 write after read");
        do_req(0, 22, '0, 2'b11, 1 + 2 + 6, "R6 read after write");
        idle(8);

        // array disabled when unused
        cfg_array_en = 1'b0;
        idle(3);
        chk(mem_pwr == 1'b0, "R8 idle unpowered", 32'(mem_pwr), 0);
        do_req(0, 30, '0, 2'b11, 6 + 4, "R9 read from cold");
        do_req(0, 31, '0, 2'b11, 2 + 2 + 4 + 6, "R9 back-to-back cold");
        idle(8);
        chk(mem_pwr == 1'b0, "R8 powered down again", 32'(mem_pwr), 0);
        do_req(0, 30, '0, 2'b11, 6 + 4, "R7 R9 cold reread restored");
        idle(8);

        // power enabled in the acceptance cycle: partial wake
        cfg_array_en = 1'b1;
        do_req(0, 40, '0, 2'b11, 6 + 3, "R9 partial wake");
        idle(8);
        do_req(0, 40, '0, 2'b11, 6, "R9 no wake when awake");
        idle(8);

        chk(exp_q.size() == 0, "R2 all responses seen", 32'(exp_q.size()), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule